// File: doc/BRIEF.md
# Descriptor-Based Frame Receive Engine

This block moves incoming frames into host-owned receive buffers. The host hands buffers over by writing their byte offsets, each with a valid bit, to a posting register. The block queues these offsets in a free-buffer FIFO. When the first byte of a frame arrives on the byte stream, the engine takes the oldest queued offset. It writes every payload byte behind the 24-byte header of that descriptor, using a byte-wide buffer-memory write port. When the frame ends, it writes the length and the source port into the header. Only after that does it write the received flag, so the host never sees a complete flag on a partly written frame.

A frame that starts while no buffer is queued is swallowed whole, and a saturating dropped-frame counter counts it. The host empties the queue by writing the flush register.

The frame input is a valid/ready stream. A byte transfers on a rising clock edge where both `s_valid` and `s_ready` are high. While `s_ready` is low, the source holds `s_data`, `s_last` and `s_port` stable. The engine lowers `s_ready` only during the five header write-back cycles that follow the last byte of a stored frame. At all other times it takes one byte per cycle. The register write port and the memory write port have no handshake: the memory must take one write in every cycle in which `mem_we` is high.

Top module: `rxd_engine`

## Requirements
- R1: A register write to byte offset 0x10 queues the offset in `reg_wdata[23:0]` only if `reg_wdata[31]` is 1. If bit 31 is 0, the write adds nothing to the queue.
- R2: A register write to byte offset 0x18 empties the free-buffer queue, whatever the data written.
- R3: The queue holds 64 offsets. A post made while 64 offsets are queued is ignored.
- R4: Byte k of a stored frame (k counted from 0) is written to buffer address offset+24+k. Each accepted byte produces exactly one memory write, in order.
- R5: Frames take queued offsets in the order in which the offsets were posted.
- R6: Header write-back follows the frame's last byte in this order:
  - the length, little-endian, at offset+8 and offset+9;
  - the port, a 16-bit little-endian field zero-extended from `s_port` as sampled on the first byte, at offset+10 and offset+11;
  - the value 0x01 at offset+4, as the last write of the frame.
- R7: For a frame of n stored bytes, the length field is 24+n+4. Its bits 15:12 are 0.
- R8: Bytes beyond the 2024th byte of a frame are accepted and discarded, with no memory write. The length field is clamped to 2048.
- R9: A frame whose first byte arrives while the queue is empty produces no memory write. It increments `drop_cnt` by one when its last byte transfers, and the count stops at 255.
- R10: `s_ready` is low for exactly 5 cycles after the last byte of a stored frame, and high otherwise.
- R11: After reset, `drop_cnt` is 0, `mem_we` is 0, `s_ready` is 1 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset (0x10 post, 0x18 flush) |
| reg_wdata | input | 32 | Register write data |
| s_valid | input | 1 | Frame byte valid |
| s_ready | output | 1 | Engine can take a byte |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Marks the last byte of a frame |
| s_port | input | 2 | Source port of the frame, sampled on its first byte |
| mem_we | output | 1 | Buffer memory byte write enable |
| mem_addr | output | 24 | Buffer memory byte address |
| mem_wdata | output | 8 | Buffer memory write byte |
| drop_cnt | output | 8 | Saturating count of frames dropped for lack of a buffer |

## Verification
The assertions check the following on every cycle:
- a flush always leaves the queue empty;
- a full queue stays full when a post arrives without a pop;
- the drop counter only ever steps by one and holds once it reaches 255;
- a length presented for write-back always lies between 28 and 2048.

Only the bench scenarios can show the following:
- payload placement and ordering across descriptors, from the captured memory image;
- the header field values, and that the flag is written after every other byte of the frame;
- that frames arriving with an empty queue leave memory untouched;
- the exact five-cycle back-pressure window.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int HDR_BYTES     = 24;
  localparam int PAYLOAD_BYTES = 2024;
  localparam int FCS_BYTES     = 4;
  localparam int DESC_BYTES    = HDR_BYTES + PAYLOAD_BYTES;
  localparam int LEN_W         = 12;
  localparam int CNT_W         = $clog2(PAYLOAD_BYTES + 1);
  localparam int OFF_RXFLAG    = 4;
  localparam int OFF_LEN       = 8;
  localparam int OFF_PORT      = 10;
  localparam int REG_POST      = 16;
  localparam int REG_FLUSH     = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_DROP, ST_WB} rx_state_e;
endpackage

// File: rtl/rxd_free_fifo.sv
module rxd_free_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  input  logic          flush,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic [CW-1:0] count
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          full, push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = store[rd_q];
  assign count   = cnt_q;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wrap_inc(wr_q);
      if (pop_ok)  rd_q <= wrap_inc(rd_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + CW'(1);
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) store[wr_q] <= push_data;
  end
endmodule

// File: rtl/rxd_sat_cnt.sv
module rxd_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    value <= '0;
    else if (inc && value != '1)   value <= value + W'(1);
  end
endmodule

// File: rtl/rxd_rx_fsm.sv
module rxd_rx_fsm
  import rxd_pkg::*;
#(
  parameter int AW     = 24,
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  input  logic [PORT_W-1:0] s_port,
  input  logic [AW-1:0]     head,
  input  logic              fifo_empty,
  output logic              pop,
  output logic              drop_inc,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              wb_busy,
  output logic [LEN_W-1:0]  len_now
);
  rx_state_e         state_q;
  logic [AW-1:0]     base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PORT_W-1:0] port_q;
  logic [2:0]        step_q;
  logic              acc;
  logic [LEN_W-1:0]  len_raw;
  logic [15:0]       port16;

  assign s_ready  = (state_q != ST_WB);
  assign acc      = s_valid && s_ready;
  assign pop      = acc && (state_q == ST_IDLE) && !fifo_empty;
  assign drop_inc = acc && s_last &&
                    (((state_q == ST_IDLE) && fifo_empty) || (state_q == ST_DROP));
  assign len_raw  = LEN_W'(HDR_BYTES + FCS_BYTES) + LEN_W'(cnt_q);
  assign len_now  = (len_raw > LEN_W'(DESC_BYTES)) ? LEN_W'(DESC_BYTES) : len_raw;
  assign port16   = 16'(port_q);
  assign wb_busy  = (state_q == ST_WB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      base_q    <= '0;
      cnt_q     <= '0;
      port_q    <= '0;
      step_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (acc) begin
          if (!fifo_empty) begin
            base_q    <= head;
            port_q    <= s_port;
            cnt_q     <= CNT_W'(1);
            step_q    <= '0;
            mem_we    <= 1'b1;
            mem_addr  <= head + AW'(HDR_BYTES);
            mem_wdata <= s_data;
            state_q   <= s_last ? ST_WB : ST_RECV;
          end else if (!s_last) begin
            state_q <= ST_DROP;
          end
        end
        ST_RECV: if (acc) begin
          if (cnt_q < CNT_W'(PAYLOAD_BYTES)) begin
            mem_we    <= 1'b1;
            mem_addr  <= base_q + AW'(HDR_BYTES) + AW'(cnt_q);
            mem_wdata <= s_data;
            cnt_q     <= cnt_q + CNT_W'(1);
          end
          if (s_last) begin
            state_q <= ST_WB;
            step_q  <= '0;
          end
        end
        ST_DROP: if (acc && s_last) state_q <= ST_IDLE;
        ST_WB: begin
          mem_we <= 1'b1;
          step_q <= step_q + 3'd1;
          case (step_q)
            3'd0: begin mem_addr <= base_q + AW'(OFF_LEN);      mem_wdata <= len_now[7:0]; end
            3'd1: begin mem_addr <= base_q + AW'(OFF_LEN + 1);  mem_wdata <= 8'(len_now >> 8); end
            3'd2: begin mem_addr <= base_q + AW'(OFF_PORT);     mem_wdata <= port16[7:0]; end
            3'd3: begin mem_addr <= base_q + AW'(OFF_PORT + 1); mem_wdata <= port16[15:8]; end
            default: begin
              mem_addr  <= base_q + AW'(OFF_RXFLAG);
              mem_wdata <= 8'h01;
              state_q   <= ST_IDLE;
            end
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
  import rxd_pkg::*;
#(
  parameter int AW     = 24,
  parameter int PORT_W = 2,
  parameter int DEPTH  = 64,
  parameter int REG_AW = 5,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  input  logic [PORT_W-1:0] s_port,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam int CNTW = $clog2(DEPTH) + 1;

  logic             post_w, flush_w, fifo_pop, fifo_empty, drop_inc, wb_busy;
  logic [AW-1:0]    fifo_head;
  logic [CNTW-1:0]  fifo_cnt;
  logic [LEN_W-1:0] len_now;
  logic             unused_wdata;

  assign post_w  = reg_wr_en && (reg_addr == REG_AW'(REG_POST)) && reg_wdata[31];
  assign flush_w = reg_wr_en && (reg_addr == REG_AW'(REG_FLUSH));
  assign unused_wdata = ^reg_wdata[30:AW];

  rxd_free_fifo #(.W(AW), .DEPTH(DEPTH), .CW(CNTW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(post_w), .push_data(reg_wdata[AW-1:0]),
    .pop(fifo_pop), .flush(flush_w), .head(fifo_head), .empty(fifo_empty),
    .count(fifo_cnt)
  );

  rxd_rx_fsm #(.AW(AW), .PORT_W(PORT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .s_port(s_port), .head(fifo_head),
    .fifo_empty(fifo_empty), .pop(fifo_pop), .drop_inc(drop_inc),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wb_busy(wb_busy), .len_now(len_now)
  );

  rxd_sat_cnt #(.W(DROP_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .inc(drop_inc), .value(drop_cnt)
  );
endmodule

// File: rtl/rxd_engine_chk.sv
module rxd_engine_chk #(
  parameter int DEPTH  = 64,
  parameter int REG_AW = 5,
  parameter int CW     = 7,
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic [CW-1:0]     fifo_cnt,
  input logic              fifo_pop,
  input logic [DROP_W-1:0] drop_cnt,
  input logic              wb_busy,
  input logic [11:0]       len_now
);
  logic flush_seen;
  assign flush_seen = reg_wr_en && (reg_addr == REG_AW'(24));

  // R2: a flush leaves the queue empty
  a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_seen |=> (fifo_cnt == '0));

  // R3: a full queue is not grown or disturbed by further posts
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CW'(DEPTH) && !fifo_pop && !flush_seen) |=> (fifo_cnt == CW'(DEPTH)));

  // R9: drop counter moves only in single steps
  a_r9_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_cnt) |-> (drop_cnt == $past(drop_cnt) + DROP_W'(1)));

  // R9: drop counter holds at its maximum
  a_r9_drop_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == '1) |=> (drop_cnt == '1));

  // R7 R8: written length stays within header+FCS and descriptor size
  a_r8_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    wb_busy |-> (len_now >= 12'd28 && len_now <= 12'h800));
endmodule

bind rxd_engine rxd_engine_chk #(.DEPTH(DEPTH), .REG_AW(REG_AW), .CW(CNTW), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .fifo_cnt(fifo_cnt), .fifo_pop(fifo_pop), .drop_cnt(drop_cnt),
  .wb_busy(wb_busy), .len_now(len_now)
);

// File: tb/tb_rxd_engine.sv
module tb_rxd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        s_last = 1'b0;
  logic [1:0]  s_port = '0;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  drop_cnt;

  int checks = 0;
  int fails  = 0;
  int wr_seq = 1;
  logic [7:0] bmem [0:16383];
  int         bseq [0:16383];

  always #2.5 clk = ~clk;

  rxd_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .s_port(s_port), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .drop_cnt(drop_cnt)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      bmem[mem_addr[13:0]] <= mem_wdata;
      bseq[mem_addr[13:0]] <= wr_seq;
      wr_seq <= wr_seq + 1;
    end
  end

  // vector: {port[7:0], nbytes[15:0], seed[7:0]}, frame k lands in descriptor k
  localparam logic [31:0] VEC [6] = '{
    {8'd1, 16'd1,    8'h11},
    {8'd2, 16'd60,   8'h22},
    {8'd0, 16'd64,   8'h33},
    {8'd3, 16'd1500, 8'h44},
    {8'd1, 16'd2020, 8'h55},
    {8'd2, 16'd7,    8'h66}
  };

  function automatic logic [7:0] pat(input logic [7:0] seed, input int j);
    return seed ^ 8'(j) ^ 8'(j >> 8);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic send(input int n, input logic [1:0] port, input logic [7:0] seed);
    for (int j = 0; j < n; j++) begin
      s_valid = 1'b1; s_data = pat(seed, j); s_last = (j == n - 1); s_port = port;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic verify(input int base, input int n, input int port, input logic [7:0] seed);
    int stored, exp_len, bad, last_seq, len_act;
    stored = (n > 2024) ? 2024 : n;
    exp_len = 28 + stored;
    if (exp_len > 2048) exp_len = 2048;
    bad = 0;
    for (int j = 0; j < stored; j++)
      if (bmem[base + 24 + j] !== pat(seed, j) || bseq[base + 24 + j] == 0) bad++;
    check(bad == 0, "R4 R5 payload", bad, 0);
    len_act = {bmem[base + 9], bmem[base + 8]};
    check(len_act == exp_len, "R7 R8 length", len_act, exp_len);
    check({bmem[base + 11], bmem[base + 10]} == 16'(port), "R6 port",
          {bmem[base + 11], bmem[base + 10]}, port);
    check(bmem[base + 4] == 8'h01, "R6 flag", bmem[base + 4], 1);
    last_seq = bseq[base + 24 + stored - 1];
    if (bseq[base + 8] > last_seq) last_seq = bseq[base + 8];
    if (bseq[base + 11] > last_seq) last_seq = bseq[base + 11];
    check(bseq[base + 4] > last_seq, "R6 flag last", bseq[base + 4], last_seq + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    int d0, w0, lows;
    for (int i = 0; i < 16384; i++) begin bmem[i] = 8'h00; bseq[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(drop_cnt == 8'd0, "R11 drop_cnt", drop_cnt, 0);
    check(mem_we == 1'b0, "R11 mem_we", mem_we, 0);
    check(s_ready == 1'b1, "R11 R10 s_ready", s_ready, 1);

    // table: R1 posts, R5 order, frames back to back
    for (int k = 0; k < 6; k++) reg_write(5'h10, 32'h8000_0000 | (k * 32'h800));
    for (int k = 0; k < 6; k++) send(int'(VEC[k][23:8]), VEC[k][25:24], VEC[k][7:0]);
    repeat (10) @(negedge clk);
    for (int k = 0; k < 6; k++) verify(k * 2048, int'(VEC[k][23:8]), int'(VEC[k][31:24]), VEC[k][7:0]);

    // R11: queue empty after table use -> frame dropped
    d0 = drop_cnt; w0 = wr_seq;
    send(2, 2'd0, 8'h01);
    check(drop_cnt == 8'(d0 + 1), "R11 R9 empty drop", drop_cnt, d0 + 1);

    // R1: post without valid bit ignored
    reg_write(5'h10, 32'h0000_3000);
    d0 = drop_cnt; w0 = wr_seq;
    send(3, 2'd1, 8'h02);
    repeat (6) @(negedge clk);
    check(drop_cnt == 8'(d0 + 1), "R1 invalid post", drop_cnt, d0 + 1);
    check(wr_seq == w0, "R1 R9 no writes", wr_seq, w0);

    // R2: flush empties queue
    reg_write(5'h10, 32'h8000_3000);
    reg_write(5'h10, 32'h8000_3800);
    reg_write(5'h18, 32'h0);
    d0 = drop_cnt; w0 = wr_seq;
    send(4, 2'd1, 8'h03);
    repeat (6) @(negedge clk);
    check(drop_cnt == 8'(d0 + 1), "R2 flush drop", drop_cnt, d0 + 1);
    check(wr_seq == w0, "R2 R9 no writes", wr_seq, w0);

    // R8: oversize frame truncated and length clamped
    reg_write(5'h10, 32'h8000_3000);
    send(2030, 2'd3, 8'h5A);
    repeat (8) @(negedge clk);
    verify(32'h3000, 2030, 3, 8'h5A);
    check(bseq[14'h3800] == 0, "R8 no spill", bseq[14'h3800], 0);

    // R10: back-pressure window
    reg_write(5'h10, 32'h8000_0000);
    send(5, 2'd0, 8'h07);
    lows = 0;
    for (int i = 0; i < 8; i++) begin
      if (!s_ready) lows++;
      @(negedge clk);
    end
    check(lows == 5, "R10 ready low cycles", lows, 5);

    // R3: 65 posts, only 64 kept
    reg_write(5'h18, 32'h0);
    for (int i = 0; i < 65; i++) reg_write(5'h10, 32'h8000_3800);
    d0 = drop_cnt;
    for (int i = 0; i < 65; i++) send(1, 2'd0, 8'h09);
    repeat (8) @(negedge clk);
    check(drop_cnt == 8'(d0 + 1), "R3 full post ignored", drop_cnt, d0 + 1);

    // R9: saturation
    reg_write(5'h18, 32'h0);
    for (int i = 0; i < 300; i++) send(1, 2'd0, 8'h0A);
    check(drop_cnt == 8'hFF, "R9 saturate", drop_cnt, 255);

    summary();
  end
endmodule